// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This peripheral holds two identical 16-bit interval timers that are clocked from one shared functional clock and programmed over a plain synchronous register bus with halfword accesses. Each channel counts upward once per prescaled tick. The prescaler divides the clock by a power of two chosen with a 4-bit code. When the next count equals the programmed period value, the channel raises a sticky status flag and starts again from zero. In auto-reload mode it keeps running. In one-shot mode it stops by itself. Each channel drives its own interrupt line. Software acknowledges an expiry by writing a one to the status flag.

Each channel is controlled by a two-state machine. In `CH_STOP` the counter and prescaler hold still. In `CH_RUN` the prescaler advances every clock and the counter advances on each tick. The transition *start* (`CH_STOP`→`CH_RUN`) happens when software writes the control register with the enable bit set. The transition *halt* (`CH_RUN`→`CH_STOP`) happens when software writes the control register with the enable bit clear. The transition *one-shot expiry* (`CH_RUN`→`CH_STOP`) happens when the period is reached while one-shot mode is selected. The enable bit read back from the control register reports whether the machine is in `CH_RUN`.

Top module: `twin_interval_timer`

## Requirements
- R1: Channel n (n = 0, 1) decodes at byte address (n+1)*0x80. Its control register is at offset 0x0, status at 0x4, period (load) at 0x8 and counter at 0xC. Every other address reads 0, and writes to such addresses change no register.
- R2: After reset, every register of both channels reads 0, both channels are stopped and both interrupt outputs are low.
- R3: Control layout: bit 8 is the interrupt enable, bit 5 is the run enable, bit 4 selects one-shot mode (1) or auto-reload mode (0), and bits [3:0] hold the prescaler code. All other control bits read 0.
- R4: With prescaler code p in 0..8, a running channel's counter advances once every 2^p clocks, with the first advance 2^p clocks after it starts. Codes 9 to 15 divide by 256.
- R5: The counter of a running channel counts upward, one per tick.
- R6: On a tick where the incremented count equals the period value, the counter becomes 0 and status bit 0 becomes 1. The period is therefore exactly the load value in ticks.
- R7: In auto-reload mode the channel keeps counting after an expiry.
- R8: In one-shot mode an expiry clears the run enable, and the counter stays at 0.
- R9: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. If an expiry happens in the same cycle as the clearing write, the flag stays set.
- R10: A channel's interrupt output is high exactly while its status flag and its interrupt enable are both 1.
- R11: A write that clears the run enable freezes the counter. On a later start, the count resumes from the frozen value, unless the load register was written since the previous start, in which case the count restarts from 0.
- R12: Activity on one channel never changes the registers or the interrupt of the other channel.
- R13: With a load value of 0xFFFF and divide by 1, the counter reaches 0xFFFE after 65534 clocks and wraps to 0 with the flag set on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (9) | Byte address |
| bus_wdata | input | 16 | Write halfword |
| bus_rdata | output | 16 | Read halfword, combinational from the addressed register |
| irq | output | NUM_CH (2) | Per-channel interrupt, level high |

## Verification
The assertions assume that every bus strobe is known and lasts one clock. A write completes on the clock edge it is presented on. Reads have no side effects on state. The stimulus drives the bus only between clock edges, with single-cycle writes to aligned addresses. Reads happen within one low clock phase and take no cycle. The bench deliberately places a status-clearing write on the exact edge of an expiry, so that the set-wins rule is exercised under the same assumptions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W     = 16;
    localparam int CODE_W     = 4;
    localparam int MAX_CODE   = 8;
    localparam int BANK_LSB   = 7;

    localparam int BIT_IE     = 8;
    localparam int BIT_EN     = 5;
    localparam int BIT_OS     = 4;
    localparam int BIT_FLAG   = 0;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_STAT  = 2'd1,
        REG_LOAD  = 2'd2,
        REG_COUNT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int MAX_LOG = MAX_CODE,
    parameter int CW      = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] code,
    output logic          tick
);

    localparam int PCNT_W = MAX_LOG;

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] mask;
    logic [CW-1:0]     eff_code;

    // codes above the largest supported one saturate to it
    always_comb begin
        if (int'(code) > MAX_LOG) eff_code = CW'(MAX_LOG);
        else                      eff_code = code;
    end

    genvar g;
    generate
        for (g = 0; g < PCNT_W; g++) begin : g_mask
            assign mask[g] = (int'(eff_code) > g);
        end
    endgenerate

    assign tick = run && ((pcnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt_q <= '0;
        else if (!run) pcnt_q <= '0;
        else           pcnt_q <= pcnt_q + 1'b1;
    end

    // prescaler phase is cleared whenever the channel is stopped (R4)
    p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt_q == '0));

    // with divide-by-1 every running cycle ticks (R4)
    p_div1_every_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && code == '0) |-> tick);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_stat,
    input  logic          wr_load,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_rd,
    output logic [DW-1:0] stat_rd,
    output logic [DW-1:0] load_rd,
    output logic [DW-1:0] count_rd,
    output logic          irq
);

    ch_state_e         state_q, state_nx;
    logic              ie_q, os_q;
    logic [CODE_W-1:0] code_q;
    logic [DW-1:0]     load_q, count_q, count_nx, cnt_inc;
    logic              flag_q, flag_nx;
    logic              pend_q, pend_nx;
    logic              tick, hit, start;

    tmr_prescaler #(.MAX_LOG(MAX_CODE), .CW(CODE_W)) i_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == CH_RUN),
        .code (code_q),
        .tick (tick)
    );

    assign cnt_inc = count_q + 1'b1;
    assign hit     = (state_q == CH_RUN) && tick && (cnt_inc == load_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_nx;
    end

    // transitions: start, halt, one-shot expiry
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CH_STOP: if (wr_ctrl && wdata[BIT_EN]) state_nx = CH_RUN;
            CH_RUN: begin
                if (wr_ctrl)          state_nx = wdata[BIT_EN] ? CH_RUN : CH_STOP;
                else if (hit && os_q) state_nx = CH_STOP;
            end
            default: state_nx = CH_STOP;
        endcase
    end

    assign start = (state_q == CH_STOP) && (state_nx == CH_RUN);

    // datapath next values
    always_comb begin
        count_nx = count_q;
        if (start && pend_q)                    count_nx = '0;
        else if (state_q == CH_RUN && tick)     count_nx = hit ? '0 : cnt_inc;

        flag_nx = flag_q;
        if (hit)                                flag_nx = 1'b1;
        else if (wr_stat && wdata[BIT_FLAG])    flag_nx = 1'b0;

        pend_nx = pend_q;
        if (wr_load)                            pend_nx = 1'b1;
        else if (start)                         pend_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            os_q    <= 1'b0;
            code_q  <= '0;
            load_q  <= '0;
            count_q <= '0;
            flag_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ie_q   <= wdata[BIT_IE];
                os_q   <= wdata[BIT_OS];
                code_q <= wdata[CODE_W-1:0];
            end
            if (wr_load) load_q <= wdata;
            count_q <= count_nx;
            flag_q  <= flag_nx;
            pend_q  <= pend_nx;
        end
    end

    // outputs
    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[BIT_IE]        = ie_q;
        ctrl_rd[BIT_EN]        = (state_q == CH_RUN);
        ctrl_rd[BIT_OS]        = os_q;
        ctrl_rd[CODE_W-1:0]    = code_q;
        stat_rd                = '0;
        stat_rd[BIT_FLAG]      = flag_q;
        load_rd                = load_q;
        count_rd               = count_q;
        irq                    = flag_q && ie_q;
    end

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_stat && wdata[BIT_FLAG])) |=> flag_q);

    p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(state_q == CH_RUN));

    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (count_q == '0 && flag_q));

    p_oneshot_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && os_q && !wr_ctrl) |=> (state_q == CH_STOP && count_q == '0));

    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOP && !wr_ctrl) |=> $stable(count_q));

    p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[BIT_FLAG] && !hit) |=> !irq);

endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
    import tmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 9,
    parameter int DW  = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [AW-1:0]           bus_addr,
    input  logic [NCH-1:0][DW-1:0]  ctrl_rd,
    input  logic [NCH-1:0][DW-1:0]  stat_rd,
    input  logic [NCH-1:0][DW-1:0]  load_rd,
    input  logic [NCH-1:0][DW-1:0]  count_rd,
    output logic [NCH-1:0]          wr_ctrl,
    output logic [NCH-1:0]          wr_stat,
    output logic [NCH-1:0]          wr_load,
    output logic [DW-1:0]           bus_rdata
);

    localparam int BANK_W = AW - BANK_LSB;

    logic [BANK_W-1:0] bank;
    logic              in_slot;
    reg_sel_e          rsel;
    logic [NCH-1:0]    ch_hit;

    assign bank    = bus_addr[AW-1:BANK_LSB];
    assign in_slot = (bus_addr[BANK_LSB-1:4] == '0) && (bus_addr[1:0] == 2'b00);
    assign rsel    = reg_sel_e'(bus_addr[3:2]);

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_dec
            assign ch_hit[g]  = bus_sel && in_slot && (int'(bank) == g + 1);
            assign wr_ctrl[g] = ch_hit[g] && bus_wr && (rsel == REG_CTRL);
            assign wr_stat[g] = ch_hit[g] && bus_wr && (rsel == REG_STAT);
            assign wr_load[g] = ch_hit[g] && bus_wr && (rsel == REG_LOAD);
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                case (rsel)
                    REG_CTRL:  bus_rdata = ctrl_rd[i];
                    REG_STAT:  bus_rdata = stat_rd[i];
                    REG_LOAD:  bus_rdata = load_rd[i];
                    default:   bus_rdata = count_rd[i];
                endcase
            end
        end
    end

    // at most one register is written per access (R1)
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ctrl, wr_stat, wr_load}));

    // no write strobe without a bus write (R1)
    p_strobe_needs_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |-> ({wr_ctrl, wr_stat, wr_load} == '0));

endmodule

// File: rtl/twin_interval_timer.sv
module twin_interval_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2((NUM_CH + 1) << BANK_LSB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd, stat_rd, load_rd, count_rd;
    logic [NUM_CH-1:0]             wr_ctrl, wr_stat, wr_load;

    tmr_regbus #(.NCH(NUM_CH), .AW(ADDR_W), .DW(DATA_W)) i_regbus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .ctrl_rd  (ctrl_rd),
        .stat_rd  (stat_rd),
        .load_rd  (load_rd),
        .count_rd (count_rd),
        .wr_ctrl  (wr_ctrl),
        .wr_stat  (wr_stat),
        .wr_load  (wr_load),
        .bus_rdata(bus_rdata)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            tmr_channel #(.DW(DATA_W)) i_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_ctrl (wr_ctrl[g]),
                .wr_stat (wr_stat[g]),
                .wr_load (wr_load[g]),
                .wdata   (bus_wdata),
                .ctrl_rd (ctrl_rd[g]),
                .stat_rd (stat_rd[g]),
                .load_rd (load_rd[g]),
                .count_rd(count_rd[g]),
                .irq     (irq[g])
            );

            // a channel's load only changes through its own strobe (R12)
            p_load_isolated_r12: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_load[g] |=> $stable(load_rd[g]));
        end
    endgenerate

endmodule

// File: tb/test_twin_interval_timer.sv
module test_twin_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] B0 = 9'h080;
    localparam logic [8:0] B1 = 9'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { int unsigned val; string tag; } sb_item_t;
    sb_item_t    exp_q[$];
    int unsigned act_q[$];

    twin_interval_timer i_twin_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expectation/observation pairs and compares
    initial begin
        forever begin
            #1;
            while (act_q.size() != 0 && exp_q.size() != 0) begin
                int unsigned a;
                sb_item_t    e;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                checks++;
                if (a != e.val) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", e.tag, a, e.val);
                end
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [8:0] a, input int unsigned e, input string tag);
        sb_item_t it;
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        act_q.push_back(int'(bus_rdata));
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input int unsigned e, input string tag);
        sb_item_t it;
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        act_q.push_back(int'(irq));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        #5;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R2 reset state
        for (int i = 0; i < 4; i++) begin
            chk_rd(B0 + 9'(4*i), 0, "R2 ch0 reg after reset");
            chk_rd(B1 + 9'(4*i), 0, "R2 ch1 reg after reset");
        end
        chk_irq(0, "R2 irq after reset");

        // R1 unmapped addresses
        wr(9'h090, 16'hFFFF);
        wr(9'h000, 16'hFFFF);
        wr(9'h188, 16'hFFFF);
        chk_rd(9'h090, 0, "R1 unmapped read");
        chk_rd(9'h184, 0, "R1 out-of-range bank read");
        chk_rd(B0, 0, "R1 ch0 ctrl untouched");
        chk_rd(B1 + 9'h8, 0, "R1 ch1 load untouched");

        // R3 control layout
        wr(B0, 16'hFFDF);
        chk_rd(B0, 16'h011F, "R3 ctrl fields");
        chk_rd(B1, 0, "R12 ch1 ctrl unaffected");
        wr(B0, 16'h0000);

        // R5 counting up, divide by 1
        wr(B0 + 9'h8, 16'd100);
        wr(B0, 16'h0020);
        idle(10);
        chk_rd(B0 + 9'hC, 10, "R5 count after 10");
        idle(5);
        chk_rd(B0 + 9'hC, 15, "R5 count after 15");

        // R6 expiry and R7 reload
        idle(84);
        chk_rd(B0 + 9'hC, 99, "R6 count one before expiry");
        chk_rd(B0 + 9'h4, 0, "R6 flag before expiry");
        idle(1);
        chk_rd(B0 + 9'hC, 0, "R6 count wraps to 0");
        chk_rd(B0 + 9'h4, 1, "R6 flag set");
        chk_irq(0, "R10 irq masked");
        idle(3);
        chk_rd(B0 + 9'hC, 3, "R7 keeps counting");

        // R10 interrupt
        wr(B0, 16'h0120);
        chk_rd(B0 + 9'hC, 4, "R7 count after ctrl write");
        chk_irq(1, "R10 irq asserted");

        // R9 write-one-to-clear
        wr(B0 + 9'h4, 16'h0000);
        chk_rd(B0 + 9'h4, 1, "R9 write 0 keeps flag");
        wr(B0 + 9'h4, 16'h0001);
        chk_rd(B0 + 9'h4, 0, "R9 write 1 clears flag");
        chk_irq(0, "R10 irq drops");

        // R11 freeze and resume
        wr(B0, 16'h0100);
        idle(10);
        chk_rd(B0 + 9'hC, 7, "R11 frozen count");
        chk_rd(B0, 16'h0100, "R11 enable reads 0");
        wr(B0, 16'h0120);
        idle(3);
        chk_rd(B0 + 9'hC, 10, "R11 resume from frozen");
        wr(B0, 16'h0100);
        wr(B0 + 9'h8, 16'd50);
        chk_rd(B0 + 9'hC, 11, "R11 load write keeps count");
        chk_rd(B0 + 9'h8, 50, "R11 load readback");
        wr(B0, 16'h0120);
        idle(4);
        chk_rd(B0 + 9'hC, 4, "R11 restart from 0 after load");

        // R8 one-shot
        wr(B0, 16'h0100);
        wr(B0 + 9'h4, 16'h0001);
        wr(B0 + 9'h8, 16'd5);
        wr(B0, 16'h0130);
        idle(4);
        chk_rd(B0 + 9'hC, 4, "R8 counting in one-shot");
        chk_rd(B0 + 9'h4, 0, "R8 no flag yet");
        idle(1);
        chk_rd(B0, 16'h0110, "R8 enable cleared");
        chk_rd(B0 + 9'hC, 0, "R8 count at 0");
        chk_rd(B0 + 9'h4, 1, "R8 flag set");
        chk_irq(1, "R10 ch0 irq after one-shot");
        idle(3);
        chk_rd(B0 + 9'hC, 0, "R8 stays stopped");

        // R4 prescaler on ch1
        wr(B1 + 9'h8, 16'd1000);
        wr(B1, 16'h0022);
        idle(8);
        chk_rd(B1 + 9'hC, 2, "R4 div4 after 8");
        idle(3);
        chk_rd(B1 + 9'hC, 2, "R4 div4 after 11");
        idle(1);
        chk_rd(B1 + 9'hC, 3, "R4 div4 after 12");
        wr(B1, 16'h0008);
        wr(B1 + 9'h8, 16'd1000);
        wr(B1, 16'h0028);
        idle(255);
        chk_rd(B1 + 9'hC, 0, "R4 div256 before tick");
        idle(1);
        chk_rd(B1 + 9'hC, 1, "R4 div256 first tick");
        wr(B1, 16'h000C);
        wr(B1 + 9'h8, 16'd1000);
        wr(B1, 16'h002C);
        chk_rd(B1, 16'h002C, "R3 code 12 readback");
        idle(255);
        chk_rd(B1 + 9'hC, 0, "R4 code 12 before tick");
        idle(1);
        chk_rd(B1 + 9'hC, 1, "R4 code 12 as div256");

        // R12 independence
        chk_rd(B0 + 9'hC, 0, "R12 ch0 count unaffected");
        chk_rd(B0 + 9'h4, 1, "R12 ch0 flag unaffected");
        chk_rd(B1 + 9'h4, 0, "R12 ch1 flag clear");
        chk_irq(1, "R12 irq only on ch0");

        // R9 set wins over clear in same cycle
        wr(B1, 16'h0000);
        wr(B1 + 9'h8, 16'd4);
        wr(B1, 16'h0020);
        idle(3);
        wr(B1 + 9'h4, 16'h0001);
        chk_rd(B1 + 9'h4, 1, "R9 expiry wins over clear");
        chk_rd(B1 + 9'hC, 0, "R6 ch1 wrapped");
        wr(B1, 16'h0000);

        // R13 full-range wrap
        wr(B0 + 9'h4, 16'h0001);
        wr(B0 + 9'h8, 16'hFFFF);
        wr(B0, 16'h0020);
        idle(65534);
        chk_rd(B0 + 9'hC, 16'hFFFE, "R13 count at FFFE");
        chk_rd(B0 + 9'h4, 0, "R13 no flag yet");
        idle(1);
        chk_rd(B0 + 9'hC, 0, "R13 wrap to 0");
        chk_rd(B0 + 9'h4, 1, "R13 flag on wrap");

        idle(2);
        finish_run();
    end

endmodule